// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Stall Control

This block steers operands and pipeline flow for a five-stage, 32-bit, load/store integer pipeline. It resolves branches and jumps in the decode (ID) stage, and the slot after each control transfer always executes. The block keeps its own copies of the instruction words held in the ID, EX, MEM and WB stages. It takes a new fetched word each cycle. From these it decodes which registers each stage reads and writes.

It produces three results. The first is the operand source for each ALU input in EX: the register file, the WB result or the MEM result. The second is a pair of selects that let the ID-stage equality comparator for branch-if-equal take the MEM-stage ALU result in place of a register file read. The third is a stall that freezes fetch and decode and sends a bubble into EX. It stalls only when no forwarding path can supply the value in time.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, every select and `stall` is 0 and `ex_instr` is all zeros (a nop).
- R2: An ALU operand in EX whose source register equals the destination of the instruction in MEM gets select 2'b10 (MEM result). This applies to the `rs` operand on `fwd_a_sel` (bits 25:21) and to the `rt` operand on `fwd_b_sel` (bits 20:16).
- R3: When only the WB instruction writes the operand's register, the select is 2'b01 (WB result). When both MEM and WB write it, MEM wins with 2'b10. With no match the select is 2'b00 (register file).
- R4: Register 0 is never a forwarding destination and never causes a stall, even when an instruction names it as its destination.
- R5: A branch-if-equal in ID sets `cmp_fwd_a` or `cmp_fwd_b` when its `rs` or `rt` register is written by a non-load instruction now in MEM.
- R6: A load in EX whose destination is a register read by the instruction in ID raises `stall` for exactly one cycle.
- R7: A branch-if-equal in ID stalls one cycle when an ALU instruction in EX writes one of its operands. It stalls two cycles when a load writes one of its operands, once while the load is in EX and once while it is in MEM.
- R8: A jump never raises `stall`. The instruction in its delay slot is not squashed and passes into EX on the next cycle.
- R9: In a stall cycle the ID word is held and the fetched word is ignored. EX receives an all-zero nop, while the EX word moves on to MEM and the MEM word moves on to WB.
- R10: Decoding uses the major opcode in bits 31:26: 000000 register-register (destination `rd` in bits 15:11), 001000 add-immediate, 100011 load word, 101011 store word (reads `rs` and `rt`), 000100 branch-if-equal and 000010 jump. Add-immediate and load word write `rt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all stage words to nop |
| fetch_instr | input | 32 | Instruction word delivered by fetch this cycle |
| fwd_a_sel | output | 2 | Source of the EX first ALU operand: 00 regfile, 01 WB, 10 MEM |
| fwd_b_sel | output | 2 | Source of the EX second ALU operand: 00 regfile, 01 WB, 10 MEM |
| cmp_fwd_a | output | 1 | ID branch comparator first operand taken from MEM result |
| cmp_fwd_b | output | 1 | ID branch comparator second operand taken from MEM result |
| stall | output | 1 | Hold fetch and decode, insert a bubble into EX |
| ex_instr | output | 32 | Instruction word currently in EX |

## Verification
Back-to-back producer and consumer pairs separate MEM forwarding from WB forwarding. Pairs in which both older stages write the same register expose the priority between the two paths. Writes to register 0 confirm that no false forwarding or stall appears. Load followed by use, and load or ALU result followed by branch-if-equal, set the stall lengths of one and two cycles apart; the `ex_instr` nop observed during those cycles shows the held decode word and the bubble. A jump placed right after a load shows that a control transfer with no register reads never stalls and that its delay slot flows on.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
    parameter int INSTR_W = 32;
    parameter int REG_W   = 5;
    parameter int OP_W    = 6;
    parameter int SEL_W   = 2;
    parameter int N_STAGE = 4;

    localparam int OP_HI = INSTR_W - 1;
    localparam int OP_LO = INSTR_W - OP_W;
    localparam int RS_LO = OP_LO - REG_W;
    localparam int RT_LO = RS_LO - REG_W;
    localparam int RD_LO = RT_LO - REG_W;

    localparam logic [OP_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'b001000;
    localparam logic [OP_W-1:0] OPC_LW   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW   = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JMP  = 6'b000010;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } src_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] dst;
        logic             rd_rs;
        logic             rd_rt;
        logic             wr;
        logic             is_load;
        logic             is_beq;
        logic             is_jmp;
    } dec_t;

    typedef struct packed {
        logic [INSTR_W-1:0] id;
        logic [INSTR_W-1:0] ex;
        logic [INSTR_W-1:0] mem;
        logic [INSTR_W-1:0] wb;
    } pipe_t;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
    import pipe_hazard_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [OP_W-1:0]  opc;
    logic [REG_W-1:0] f_rs, f_rt, f_rd;

    assign opc  = instr[OP_HI:OP_LO];
    assign f_rs = instr[RS_LO +: REG_W];
    assign f_rt = instr[RT_LO +: REG_W];
    assign f_rd = instr[RD_LO +: REG_W];

    always_comb begin
        dec         = '0;
        dec.rs      = f_rs;
        dec.rt      = f_rt;
        unique case (opc)
            OPC_REG:  begin dec.rd_rs = 1'b1; dec.rd_rt = 1'b1; dec.dst = f_rd; end
            OPC_ADDI: begin dec.rd_rs = 1'b1; dec.dst = f_rt; end
            OPC_LW:   begin dec.rd_rs = 1'b1; dec.dst = f_rt; dec.is_load = 1'b1; end
            OPC_SW:   begin dec.rd_rs = 1'b1; dec.rd_rt = 1'b1; end
            OPC_BEQ:  begin dec.rd_rs = 1'b1; dec.rd_rt = 1'b1; dec.is_beq = 1'b1; end
            OPC_JMP:  dec.is_jmp = 1'b1;
            default:  ;
        endcase
        dec.wr = (dec.dst != '0);
    end
endmodule

// File: rtl/ex_forward.sv
module ex_forward
    import pipe_hazard_pkg::*;
(
    input  dec_t             ex_dec,
    input  dec_t             mem_dec,
    input  dec_t             wb_dec,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b
);
    localparam int N_OPND = 2;
    logic [SEL_W-1:0] sel [N_OPND];

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        logic [REG_W-1:0] src;
        logic             used;
        assign src  = (g == 0) ? ex_dec.rs : ex_dec.rt;
        assign used = (g == 0) ? ex_dec.rd_rs : ex_dec.rd_rt;
        always_comb begin
            if (used && mem_dec.wr && mem_dec.dst == src)
                sel[g] = SRC_MEM;
            else if (used && wb_dec.wr && wb_dec.dst == src)
                sel[g] = SRC_WB;
            else
                sel[g] = SRC_RF;
        end
    end

    assign sel_a = sel[0];
    assign sel_b = sel[1];
endmodule

// File: rtl/id_hazard.sv
module id_hazard
    import pipe_hazard_pkg::*;
(
    input  dec_t id_dec,
    input  dec_t ex_dec,
    input  dec_t mem_dec,
    output logic cmp_a,
    output logic cmp_b,
    output logic stall
);
    logic hit_ex_rs, hit_ex_rt, hit_mem_rs, hit_mem_rt;
    logic load_use, beq_wait;

    assign hit_ex_rs  = id_dec.rd_rs && ex_dec.wr  && ex_dec.dst  == id_dec.rs;
    assign hit_ex_rt  = id_dec.rd_rt && ex_dec.wr  && ex_dec.dst  == id_dec.rt;
    assign hit_mem_rs = id_dec.rd_rs && mem_dec.wr && mem_dec.dst == id_dec.rs;
    assign hit_mem_rt = id_dec.rd_rt && mem_dec.wr && mem_dec.dst == id_dec.rt;

    assign cmp_a = id_dec.is_beq && hit_mem_rs && !mem_dec.is_load;
    assign cmp_b = id_dec.is_beq && hit_mem_rt && !mem_dec.is_load;

    assign load_use = ex_dec.is_load && (hit_ex_rs || hit_ex_rt);
    assign beq_wait = id_dec.is_beq &&
                      ((hit_ex_rs || hit_ex_rt) ||
                       (mem_dec.is_load && (hit_mem_rs || hit_mem_rt)));

    assign stall = load_use || beq_wait;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import pipe_hazard_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic [SEL_W-1:0]   fwd_a_sel,
    output logic [SEL_W-1:0]   fwd_b_sel,
    output logic               cmp_fwd_a,
    output logic               cmp_fwd_b,
    output logic               stall,
    output logic [INSTR_W-1:0] ex_instr
);
    pipe_t pipe_d, pipe_q;
    dec_t  dec [N_STAGE];
    logic [INSTR_W-1:0] stage_word [N_STAGE];

    assign stage_word[0] = pipe_q.id;
    assign stage_word[1] = pipe_q.ex;
    assign stage_word[2] = pipe_q.mem;
    assign stage_word[3] = pipe_q.wb;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_dec
        pipe_decode u_dec (.instr(stage_word[s]), .dec(dec[s]));
    end

    ex_forward u_exf (
        .ex_dec(dec[1]), .mem_dec(dec[2]), .wb_dec(dec[3]),
        .sel_a(fwd_a_sel), .sel_b(fwd_b_sel)
    );

    id_hazard u_idh (
        .id_dec(dec[0]), .ex_dec(dec[1]), .mem_dec(dec[2]),
        .cmp_a(cmp_fwd_a), .cmp_b(cmp_fwd_b), .stall(stall)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.wb  = pipe_q.mem;
        pipe_d.mem = pipe_q.ex;
        if (stall) begin
            pipe_d.ex = '0;
        end else begin
            pipe_d.ex = pipe_q.id;
            pipe_d.id = fetch_instr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign ex_instr = pipe_q.ex;

    // R8
    jump_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec[0].is_jmp |-> !stall);

    // R9
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_instr == '0));

    // R9
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (pipe_q.id == $past(pipe_q.id)));

    // R9
    mem_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pipe_q.mem == $past(ex_instr)));

    // R4
    r0_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec[1].rs == '0) |-> (fwd_a_sel == SRC_RF));

    // R5
    cmp_needs_beq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fwd_a || cmp_fwd_b) |-> dec[0].is_beq);
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_instr;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        cmp_fwd_a, cmp_fwd_b, stall;
    logic [31:0] ex_instr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .cmp_fwd_a(cmp_fwd_a), .cmp_fwd_b(cmp_fwd_b),
        .stall(stall), .ex_instr(ex_instr)
    );

    typedef struct {
        logic [1:0]  fa, fb;
        logic        ca, cb, st;
        logic [31:0] ex;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // bench-side pipeline model
    logic [31:0] m_id = '0, m_ex = '0, m_mem = '0, m_wb = '0;

    function automatic logic [31:0] rr(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] imm(logic [5:0] op, int rs, int rt, int k);
        return {op, 5'(rs), 5'(rt), 16'(k)};
    endfunction
    function automatic logic [31:0] jmp(int tgt);
        return {6'b000010, 26'(tgt)};
    endfunction

    function automatic int writes(logic [31:0] w);
        case (w[31:26])
            6'b000000: return int'(w[15:11]);
            6'b001000, 6'b100011: return int'(w[20:16]);
            default: return 0;
        endcase
    endfunction
    function automatic int reads_a(logic [31:0] w);
        case (w[31:26])
            6'b000000, 6'b001000, 6'b100011, 6'b101011, 6'b000100: return int'(w[25:21]);
            default: return 0;
        endcase
    endfunction
    function automatic int reads_b(logic [31:0] w);
        case (w[31:26])
            6'b000000, 6'b101011, 6'b000100: return int'(w[20:16]);
            default: return 0;
        endcase
    endfunction
    function automatic bit is_lw(logic [31:0] w);  return w[31:26] == 6'b100011; endfunction
    function automatic bit is_beq(logic [31:0] w); return w[31:26] == 6'b000100; endfunction

    function automatic logic [1:0] pick(int src);
        if (src != 0 && src == writes(m_mem)) return 2'b10;
        if (src != 0 && src == writes(m_wb))  return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit model_stall();
        int a = reads_a(m_id);
        int b = reads_b(m_id);
        int we = writes(m_ex);
        int wm = writes(m_mem);
        bit ex_hit  = (we != 0) && (we == a || we == b);
        bit mem_hit = (wm != 0) && (wm == a || wm == b);
        return (is_lw(m_ex) && ex_hit) || (is_beq(m_id) && (ex_hit || (is_lw(m_mem) && mem_hit)));
    endfunction

    // one cycle: push expectation for current state, present word, advance model
    task automatic step(input logic [31:0] w, input string tag, output bit held);
        exp_t e;
        @(negedge clk);
        e.fa  = pick(reads_a(m_ex));
        e.fb  = pick(reads_b(m_ex));
        e.ca  = is_beq(m_id) && reads_a(m_id) != 0 && reads_a(m_id) == writes(m_mem) && !is_lw(m_mem);
        e.cb  = is_beq(m_id) && reads_b(m_id) != 0 && reads_b(m_id) == writes(m_mem) && !is_lw(m_mem);
        e.st  = model_stall();
        e.ex  = m_ex;
        e.tag = tag;
        sb.push_back(e);
        fetch_instr = w;
        held  = e.st;
        m_wb  = m_mem;
        m_mem = m_ex;
        if (held) m_ex = '0;
        else begin m_ex = m_id; m_id = w; end
    endtask

    // driver: re-presents a word until it is accepted into ID
    task automatic issue(input logic [31:0] w, input string tag);
        bit held;
        do step(w, tag, held); while (held);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 4; i++) issue('0, tag);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (fwd_a_sel !== e.fa || fwd_b_sel !== e.fb || cmp_fwd_a !== e.ca ||
                    cmp_fwd_b !== e.cb || stall !== e.st || ex_instr !== e.ex) begin
                    errors++;
                    $display("FAIL %s: got fa=%b fb=%b ca=%b cb=%b st=%b ex=%h exp fa=%b fb=%b ca=%b cb=%b st=%b ex=%h",
                             e.tag, fwd_a_sel, fwd_b_sel, cmp_fwd_a, cmp_fwd_b, stall, ex_instr,
                             e.fa, e.fb, e.ca, e.cb, e.st, e.ex);
                end
            end
        end
    end

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fetch_instr = rr(1, 2, 3, 6'b100000);
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if (fwd_a_sel !== 2'b00 || fwd_b_sel !== 2'b00 || cmp_fwd_a || cmp_fwd_b || stall || ex_instr !== '0) begin
            errors++;
            $display("FAIL R1: got fa=%b fb=%b st=%b ex=%h expected all zero", fwd_a_sel, fwd_b_sel, stall, ex_instr);
        end
        @(posedge clk);
        rst_n = 1'b1;
        fetch_instr = '0;

        // R1 first sample after release
        issue('0, "R1");
        // R2: MEM forwarding on both operands
        issue(rr(2, 3, 1, 6'b100000), "R2");
        issue(rr(1, 5, 4, 6'b100010), "R2");
        issue(rr(6, 1, 7, 6'b100000), "R2");
        drain("R2");
        // R3: WB only, then MEM over WB priority
        issue(rr(2, 3, 1, 6'b100000), "R3");
        issue('0, "R3");
        issue(rr(5, 1, 6, 6'b100000), "R3");
        issue(rr(2, 3, 7, 6'b100000), "R3");
        issue(rr(4, 5, 7, 6'b000010), "R3");
        issue(rr(7, 7, 8, 6'b100000), "R3");
        drain("R3");
        // R4: destination register 0
        issue(rr(1, 2, 0, 6'b100000), "R4");
        issue(imm(6'b100011, 1, 0, 4), "R4");
        issue(rr(0, 0, 3, 6'b100000), "R4");
        issue(imm(6'b000100, 0, 0, 2), "R4");
        drain("R4");
        // R6 / R9: load followed by use
        issue(imm(6'b100011, 1, 9, 0), "R6");
        issue(rr(9, 1, 10, 6'b100000), "R6");
        issue(rr(10, 9, 11, 6'b100000), "R9");
        drain("R6");
        // R5: beq compare fed from MEM ALU result
        issue(rr(2, 3, 11, 6'b100000), "R5");
        issue('0, "R5");
        issue(imm(6'b000100, 11, 0, 3), "R5");
        issue(rr(1, 1, 12, 6'b100000), "R5");
        issue(rr(2, 2, 13, 6'b100000), "R5");
        issue('0, "R5");
        issue(imm(6'b000100, 1, 13, 3), "R5");
        drain("R5");
        // R7: beq right after ALU write, then after a load (two stalls)
        issue(rr(2, 3, 14, 6'b100000), "R7");
        issue(imm(6'b000100, 0, 14, 1), "R7");
        issue('0, "R7");
        issue(imm(6'b100011, 1, 12, 0), "R7");
        issue(imm(6'b000100, 12, 12, 5), "R7");
        issue('0, "R7");
        drain("R7");
        // R8: jump after a load, delay slot flows on
        issue(imm(6'b100011, 1, 13, 0), "R8");
        issue(jmp(20), "R8");
        issue(rr(13, 2, 14, 6'b100000), "R8");
        drain("R8");
        // R10: add-immediate and store decoding
        issue(imm(6'b001000, 1, 15, 7), "R10");
        issue(imm(6'b101011, 2, 15, 0), "R10");
        issue(imm(6'b101011, 15, 3, 0), "R10");
        drain("R10");

        @(negedge clk);
        #4;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule